// File: doc/BRIEF.md
# Wide-Screen Signalling Line Encoder (625-line)

This block produces the bi-phase wide-screen signalling burst that a 625-line video encoder places on the first half of a chosen vertical blanking line (line 23 by default). On each qualifying line it emits a 137-element sequence in this order: a fixed 29-element run-in, a fixed 24-element start code, and 14 data bits of 6 elements each. The output is a per-clock high/low level, and the luma path turns it into the signalling amplitude. Everything outside the burst window stays low, so the line shows blanking.

Software writes the payload in two byte writes. The low byte is only staged. The write of the high byte commits the full 14-bit word, which is sent on every later qualifying line until another commit replaces it. The burst starts at a fixed pixel-clock offset from the line reference. The 200 ns element period does not divide the pixel clock evenly, so a fractional accumulator places each element boundary within one clock of its ideal position.

Top module: `wss_line_encoder`

## Requirements
- R1: After reset, `elem_out` and `wss_on` are 0, and no burst starts until a commit has happened.
- R2: Before the first write with `wr_sel`=1, no burst is produced on any line, even when every other start condition holds.
- R3: A burst begins with the 29-element run-in 0x1F1C71C7, sent most significant element first, followed at once by the 24-element start code 0x1E3C1F, also sent most significant element first.
- R4: After the start code, payload bits 0 to 13 follow in ascending order. Each bit takes 6 elements: a 0 is sent as low,low,low,high,high,high and a 1 as high,high,high,low,low,low. Payload bits 7:0 come from the last byte written with `wr_sel`=0. Payload bits 13:8 come from `wr_data[5:0]` of the commit write (`wr_sel`=1), and `wr_data[7:6]` of that write is unused.
- R5: Let n be the number of clock edges since the edge that sampled `hpos`=START_CLK. During the burst the output shows element floor(n*STEP_NUM/STEP_DEN), which is floor(10n/59) by default, for every n where that index is below 137. The window is therefore 809 clocks by default, and after it the output returns to 0.
- R6: A burst starts only on the line whose `line_num` equals TARGET_LINE (23).
- R7: A burst starts only if both `mode_625` and `wss_en` are 1 at the start edge. If either is 0, the whole line stays low.
- R8: A write with `wr_sel`=0 alone does not change the transmitted payload. A committed payload repeats unchanged on every later qualifying line.
- R9: A commit made while a burst is running does not alter that burst. The new payload appears from the next qualifying line.
- R10: `wss_on` is 1 exactly during the burst window, and `elem_out` is 0 whenever `wss_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: stage low payload byte; 1: high payload bits and commit |
| wr_data | input | 8 | Write data |
| mode_625 | input | 1 | 1 selects the 625-line system |
| wss_en | input | 1 | Signalling enable |
| line_num | input | LINE_W | Current line number from the line counter |
| hpos | input | HPOS_W | Pixel-clock position from the line reference |
| elem_out | output | 1 | Current element level (1 = high level) |
| wss_on | output | 1 | Burst window active, used as the luma mux select |

## Verification
The bench compares every clock of each line against a frame it builds itself. An off-by-one in the accumulator would therefore show up as a boundary shifted by one clock somewhere in the 809-clock window, and a wrong end condition would leave the window one clock too long or too short. Other targeted mistakes are a run-in or start code sent least significant element first, a swapped bi-phase polarity, and a reversed bit order. A design that commits on the low-byte write would send the payload early. A design that drives the live register into the shifter would corrupt the burst when a commit arrives mid-line. The bench also runs lines that fail one start condition at a time (wrong line, system bit off, enable off, no commit yet), and on each of these any output activity is an error.

// File: rtl/wss_pkg.sv
package wss_pkg;
   localparam int RUNIN_LEN   = 29;
   localparam int START_LEN   = 24;
   localparam int DATA_BITS   = 14;
   localparam int ELEM_PER_B  = 6;
   localparam int FRAME_LEN   = RUNIN_LEN + START_LEN + DATA_BITS * ELEM_PER_B;
   localparam int HALF_B      = ELEM_PER_B / 2;

   localparam logic [RUNIN_LEN-1:0] RUNIN_PAT = 29'h1F1C71C7;
   localparam logic [START_LEN-1:0] START_PAT = 24'h1E3C1F;

   typedef logic [FRAME_LEN-1:0] frame_t;
   typedef logic [DATA_BITS-1:0] payload_t;

   // Assemble the full element sequence; bit FRAME_LEN-1 is transmitted first.
   function automatic frame_t build_frame(input payload_t pay);
      frame_t f;
      int     pos;
      f   = '0;
      pos = FRAME_LEN - 1;
      for (int k = RUNIN_LEN - 1; k >= 0; k--) begin
         f[pos] = RUNIN_PAT[k];
         pos--;
      end
      for (int k = START_LEN - 1; k >= 0; k--) begin
         f[pos] = START_PAT[k];
         pos--;
      end
      for (int b = 0; b < DATA_BITS; b++) begin
         for (int e = 0; e < ELEM_PER_B; e++) begin
            f[pos] = (e < HALF_B) ? pay[b] : ~pay[b];
            pos--;
         end
      end
      return f;
   endfunction
endpackage

// File: rtl/wss_payload_regs.sv
module wss_payload_regs
   import wss_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   output payload_t   payload,
   output logic       payload_ok
);
   localparam int HI_BITS = DATA_BITS - 8;

   logic [7:0] stage_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_lo   <= '0;
         payload    <= '0;
         payload_ok <= 1'b0;
      end else if (wr_en) begin
         if (!wr_sel) begin
            stage_lo <= wr_data;
         end else begin
            payload    <= {wr_data[HI_BITS-1:0], stage_lo};
            payload_ok <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/wss_elem_timer.sv
module wss_elem_timer #(
   parameter int STEP_NUM  = 10,
   parameter int STEP_DEN  = 59,
   parameter int N_ELEMS   = 137
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic tick
);
   localparam int ACC_W = $clog2(STEP_NUM + STEP_DEN + 1);
   localparam int IDX_W = $clog2(N_ELEMS + 1);

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_sum;
   logic [IDX_W-1:0] idx;
   logic             last_elem;

   assign acc_sum   = acc + ACC_W'(STEP_NUM);
   assign tick      = busy && (acc_sum >= ACC_W'(STEP_DEN));
   assign last_elem = (idx == IDX_W'(N_ELEMS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         acc  <= '0;
         idx  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         acc  <= '0;
         idx  <= '0;
      end else if (busy) begin
         if (tick) begin
            acc <= acc_sum - ACC_W'(STEP_DEN);
            if (last_elem) begin
               busy <= 1'b0;
               idx  <= '0;
            end else begin
               idx <= idx + 1'b1;
            end
         end else begin
            acc <= acc_sum;
         end
      end
   end
endmodule

// File: rtl/wss_frame_shift.sv
module wss_frame_shift
   import wss_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  payload_t payload,
   input  logic     advance,
   output logic     head
);
   frame_t sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
      end else if (load) begin
         sreg <= build_frame(payload);
      end else if (advance) begin
         sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
      end
   end

   assign head = sreg[FRAME_LEN-1];
endmodule

// File: rtl/wss_line_encoder.sv
module wss_line_encoder
   import wss_pkg::*;
#(
   parameter int LINE_W      = 10,
   parameter int HPOS_W      = 12,
   parameter int TARGET_LINE = 23,
   parameter int START_CLK   = 325,
   parameter int STEP_NUM    = 10,
   parameter int STEP_DEN    = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [7:0]        wr_data,
   input  logic              mode_625,
   input  logic              wss_en,
   input  logic [LINE_W-1:0] line_num,
   input  logic [HPOS_W-1:0] hpos,
   output logic              elem_out,
   output logic              wss_on
);
   generate
      if (STEP_NUM <= 0 || STEP_NUM >= STEP_DEN) begin : g_bad_step
         $error("element step must satisfy 0 < STEP_NUM < STEP_DEN");
      end
      if (START_CLK >= (1 << HPOS_W)) begin : g_bad_start
         $error("START_CLK does not fit in HPOS_W");
      end
      if (TARGET_LINE >= (1 << LINE_W)) begin : g_bad_line
         $error("TARGET_LINE does not fit in LINE_W");
      end
   endgenerate

   payload_t payload;
   logic     payload_ok;
   logic     busy;
   logic     tick;
   logic     head;
   logic     kick;

   wss_payload_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .payload    (payload),
      .payload_ok (payload_ok)
   );

   assign kick = !busy && payload_ok && mode_625 && wss_en
              && (line_num == LINE_W'(TARGET_LINE))
              && (hpos == HPOS_W'(START_CLK));

   wss_elem_timer #(
      .STEP_NUM (STEP_NUM),
      .STEP_DEN (STEP_DEN),
      .N_ELEMS  (FRAME_LEN)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (kick),
      .busy  (busy),
      .tick  (tick)
   );

   wss_frame_shift u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (kick),
      .payload (payload),
      .advance (tick),
      .head    (head)
   );

   assign wss_on   = busy;
   assign elem_out = busy & head;
endmodule

// File: rtl/wss_line_encoder_chk.sv
module wss_line_encoder_chk #(
   parameter int LINE_W      = 10,
   parameter int TARGET_LINE = 23,
   parameter int STEP_NUM    = 10,
   parameter int STEP_DEN    = 59
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic              mode_625,
   input logic              wss_en,
   input logic [LINE_W-1:0] line_num,
   input logic              elem_out,
   input logic              wss_on
);
   localparam int WIN = (wss_pkg::FRAME_LEN * STEP_DEN + STEP_NUM - 1) / STEP_NUM;

   logic        seen_commit;
   logic [15:0] win_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_commit <= 1'b0;
         win_cnt     <= '0;
      end else begin
         if (wr_en && wr_sel) seen_commit <= 1'b1;
         if (wss_on) win_cnt <= win_cnt + 1'b1;
         else        win_cnt <= '0;
      end
   end

   AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !wss_on |-> !elem_out); // R10

   AST_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wss_on) |-> seen_commit); // R2

   AST_RIGHT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wss_on) |-> ($past(line_num) == LINE_W'(TARGET_LINE))); // R6

   AST_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wss_on) |-> ($past(mode_625) && $past(wss_en))); // R7

   AST_RUNIN_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wss_on) |-> elem_out); // R3

   AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wss_on) |-> (win_cnt == 16'(WIN))); // R5
endmodule

bind wss_line_encoder wss_line_encoder_chk #(
   .LINE_W      (LINE_W),
   .TARGET_LINE (TARGET_LINE),
   .STEP_NUM    (STEP_NUM),
   .STEP_DEN    (STEP_DEN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .mode_625 (mode_625),
   .wss_en   (wss_en),
   .line_num (line_num),
   .elem_out (elem_out),
   .wss_on   (wss_on)
);

// File: tb/sim_wss_line_encoder.sv
module sim_wss_line_encoder;
   localparam int START    = 325;
   localparam int NUM      = 10;
   localparam int DEN      = 59;
   localparam int NELEM    = 137;
   localparam int LINE_CLK = 1200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       mode_625 = 1'b1;
   logic       wss_en = 1'b1;
   logic [9:0] line_num = '0;
   logic [11:0] hpos = '0;
   logic       elem_out;
   logic       wss_on;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   wss_line_encoder u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mode_625(mode_625), .wss_en(wss_en), .line_num(line_num), .hpos(hpos),
      .elem_out(elem_out), .wss_on(wss_on)
   );

   function automatic logic [NELEM-1:0] ref_frame(input logic [13:0] d);
      logic [NELEM-1:0] f;
      f = '0;
      f[136:108] = 29'h1F1C71C7;
      f[107:84]  = 24'h1E3C1F;
      for (int i = 0; i < 14; i++) begin
         f[83-6*i] = d[i];
         f[82-6*i] = d[i];
         f[81-6*i] = d[i];
         f[80-6*i] = ~d[i];
         f[79-6*i] = ~d[i];
         f[78-6*i] = ~d[i];
      end
      return f;
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input int h);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at hpos %0d: actual=%0b expected=%0b", req, h, act, exp);
      end
   endtask

   task automatic write_reg(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic commit(input logic [13:0] d);
      write_reg(1'b0, d[7:0]);
      write_reg(1'b1, {2'b11, d[13:8]});
   endtask

   // Run one line; optional mid-burst commit of inj.
   task automatic run_line(input string req, input int ln, input bit send,
                           input logic [13:0] d, input bit inject, input logic [13:0] inj);
      logic [NELEM-1:0] f;
      f = ref_frame(d);
      @(negedge clk);
      line_num = 10'(ln);
      for (int h = 0; h < LINE_CLK; h++) begin
         hpos = 12'(h);
         if (inject && h == 600) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = inj[7:0]; end
         else if (inject && h == 601) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = {2'b00, inj[13:8]}; end
         else wr_en = 1'b0;
         @(negedge clk);
         begin
            int  n;
            int  k;
            bit  inwin;
            n = h - START;
            k = (n >= 0) ? (n * NUM) / DEN : -1;
            inwin = send && n >= 0 && k < NELEM;
            check({req, " window"}, wss_on, inwin, h);
            check(req, elem_out, inwin ? f[NELEM-1-k] : 1'b0, h);
         end
      end
      wr_en = 1'b0;
      line_num = 10'd0;
      hpos = '0;
   endtask

   task automatic t_reset();
      check("R1 reset elem_out", elem_out, 1'b0, -1);
      check("R1 reset wss_on", wss_on, 1'b0, -1);
   endtask

   task automatic t_no_commit();
      run_line("R2 no commit", 23, 1'b0, 14'h0, 1'b0, 14'h0);
      write_reg(1'b0, 8'h5A);
      run_line("R8 low byte only", 23, 1'b0, 14'h0, 1'b0, 14'h0);
   endtask

   task automatic t_basic();
      commit(14'h2C6B);
      // R3 run-in/start, R4 bit coding, R5 timing, R10 window
      run_line("R4 payload 2C6B", 23, 1'b1, 14'h2C6B, 1'b0, 14'h0);
      run_line("R8 persists", 23, 1'b1, 14'h2C6B, 1'b0, 14'h0);
   endtask

   task automatic t_gating();
      run_line("R6 line 22", 22, 1'b0, 14'h0, 1'b0, 14'h0);
      run_line("R6 line 24", 24, 1'b0, 14'h0, 1'b0, 14'h0);
      mode_625 = 1'b0;
      run_line("R7 525-line mode", 23, 1'b0, 14'h0, 1'b0, 14'h0);
      mode_625 = 1'b1; wss_en = 1'b0;
      run_line("R7 disabled", 23, 1'b0, 14'h0, 1'b0, 14'h0);
      wss_en = 1'b1;
   endtask

   task automatic t_patterns();
      commit(14'h0000);
      run_line("R4 all zero", 23, 1'b1, 14'h0000, 1'b0, 14'h0);
      commit(14'h3FFF);
      run_line("R3 R5 all ones", 23, 1'b1, 14'h3FFF, 1'b0, 14'h0);
   endtask

   task automatic t_midline();
      commit(14'h1234);
      run_line("R9 ongoing burst", 23, 1'b1, 14'h1234, 1'b1, 14'h0ACE);
      run_line("R9 next line", 23, 1'b1, 14'h0ACE, 1'b0, 14'h0);
   endtask

   initial begin
      #1;
      t_reset();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_no_commit();
      t_basic();
      t_gating();
      t_patterns();
      t_midline();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20_000_000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule